// File: doc/BRIEF.md
# Rotate and Shift Unit

This block carries out the shift-class operations of a small 16-bit processor. Each operation takes a 16-bit source operand and a 2-bit function code, and produces a 16-bit result for the destination register. The operation can be a rotate left, a rotate right, a logical shift left or a logical shift right. The distance comes from a small shift-amount register that lives inside the block. Software can write and read this register, but it holds only four bits. Rotates behave as if the operand were doubled into a 32-bit word, {src, src}, and that word were shifted. A left rotate keeps the upper half of the result and a right rotate keeps the lower half. The block does not touch the status flags.

Operations enter on a valid/ready input stream and leave on a valid/ready output stream. A single output register sits between the two streams, so a result appears one cycle after its operation is accepted. The input is accepted only when the output register is empty or is being drained in the same cycle: `op_ready = !res_valid || res_ready`. While `res_valid` is high and `res_ready` is low, the result and its valid flag do not change, and no new operation is taken. A beat counts as active only when `op_valid` is high. Without an active beat, no result is produced.

Top module: `rsu_top`

## Requirements
- R1: Function code 2'b00 (rotate left) returns the upper 16 bits of {src, src} shifted left by the held amount.
- R2: Function code 2'b01 (rotate right) returns the lower 16 bits of {src, src} shifted right by the held amount.
- R3: Function code 2'b10 is a logical shift left of src, and the vacated low bits are zero.
- R4: Function code 2'b11 is a logical shift right of src, and the vacated high bits are zero.
- R5: With a held amount of zero, every function code returns src unchanged.
- R6: A write to the amount register stores only bits [3:0] of the written word. The read port returns the held value zero-extended to 16 bits, starting the cycle after the write.
- R7: An operation uses the amount held when it is accepted. A write in the same cycle affects only later operations.
- R8: While res_valid is high and res_ready is low, res_valid stays high and res_data stays stable.
- R9: op_ready equals !res_valid || res_ready. An accepted operation raises res_valid on the next cycle. res_valid falls only after a handshake with no new operation accepted.
- R10: After reset, res_valid is low and the amount register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| amt_wr_en | input | 1 | Write strobe for the amount register |
| amt_wr_data | input | 16 | Write word; only bits [3:0] are kept |
| amt_rd_data | output | 16 | Held amount, zero-extended |
| op_valid | input | 1 | An active shift-class operation is offered |
| op_ready | output | 1 | The operation is accepted this cycle |
| op_func | input | 2 | 00 rotl, 01 rotr, 10 shl, 11 shr |
| op_src | input | 16 | Source operand |
| res_valid | output | 1 | A result is held for the destination |
| res_ready | input | 1 | The destination takes the result |
| res_data | output | 16 | Result value |

## Verification
A corrupted amount register shows on `amt_rd_data` one cycle after the bad write. It also shows on `res_data` one cycle after the next accepted operation. A wrong stage in the shifter network only shows for amounts that have that stage's bit set. For this reason every function code is swept over all sixteen amounts with several operand patterns, and each result is compared one cycle after acceptance. A wrong occupancy state in the output register shows at once on `op_ready` in the same cycle, or on `res_valid` in the next cycle. Random back-pressure exercises this on every clock.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
  typedef enum logic [1:0] {
    FN_ROTL = 2'b00,
    FN_ROTR = 2'b01,
    FN_SHL  = 2'b10,
    FN_SHR  = 2'b11
  } rsu_func_e;
endpackage

// File: rtl/rsu_amount_reg.sv
module rsu_amount_reg #(
  parameter int W  = 16,
  parameter int AW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  output logic [AW-1:0] amount,
  output logic [W-1:0]  rd_data
);
  logic amt_unused_hi;
  assign amt_unused_hi = ^wr_data[W-1:AW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     amount <= '0;
    else if (wr_en) amount <= wr_data[AW-1:0];
  end

  assign rd_data = {{(W-AW){1'b0}}, amount};

  // R6: the read port shows the truncated write one cycle later
  a_r6_write_truncated: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == {{(W-AW){1'b0}}, $past(wr_data[AW-1:0])});
  // R6: without a write, the held value does not change
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));
endmodule

// File: rtl/rsu_barrel.sv
module rsu_barrel
  import rsu_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  src,
  input  rsu_func_e     func,
  input  logic [AW-1:0] amount,
  output logic [W-1:0]  result
);
  // Each stage is a W-bit window onto a doubled word {v, fill}.
  // fill = v gives a rotate, fill = 0 gives a logical shift.
  logic rotate;
  logic left;
  assign rotate = (func == FN_ROTL) || (func == FN_ROTR);
  assign left   = (func == FN_ROTL) || (func == FN_SHL);

  logic [W-1:0] lstage [AW+1];
  logic [W-1:0] rstage [AW+1];
  assign lstage[0] = src;
  assign rstage[0] = src;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int K = 1 << s;
    logic [W-1:0] lfill, rfill;
    assign lfill = rotate ? lstage[s] : '0;
    assign rfill = rotate ? rstage[s] : '0;
    assign lstage[s+1] = amount[s] ? ((lstage[s] << K) | (lfill >> (W-K))) : lstage[s];
    assign rstage[s+1] = amount[s] ? ((rstage[s] >> K) | (rfill << (W-K))) : rstage[s];
  end

  assign result = left ? lstage[AW] : rstage[AW];
endmodule

// File: rtl/rsu_out_stage.sv
module rsu_out_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R8: a stalled result holds
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R9: an accepted beat produces a result next cycle
  a_r9_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R9: valid drops only after a handshake with no new beat
  a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready) && !$past(in_valid));
endmodule

// File: rtl/rsu_top.sv
module rsu_top
  import rsu_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         amt_wr_en,
  input  logic [W-1:0] amt_wr_data,
  output logic [W-1:0] amt_rd_data,
  input  logic         op_valid,
  output logic         op_ready,
  input  logic [1:0]   op_func,
  input  logic [W-1:0] op_src,
  output logic         res_valid,
  input  logic         res_ready,
  output logic [W-1:0] res_data
);
  logic [AW-1:0] amount;
  logic [W-1:0]  shifted;

  rsu_amount_reg #(.W(W), .AW(AW)) i_amt (
    .clk(clk), .rst_n(rst_n), .wr_en(amt_wr_en), .wr_data(amt_wr_data),
    .amount(amount), .rd_data(amt_rd_data)
  );

  rsu_barrel #(.W(W), .AW(AW)) i_barrel (
    .src(op_src), .func(rsu_func_e'(op_func)), .amount(amount), .result(shifted)
  );

  rsu_out_stage #(.W(W)) i_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(op_valid), .in_ready(op_ready), .in_data(shifted),
    .out_valid(res_valid), .out_ready(res_ready), .out_data(res_data)
  );

  // R5: a zero amount passes the operand through
  a_r5_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_ready && amt_rd_data == '0 |=> res_data == $past(op_src));
endmodule

// File: tb/test_rsu_top.sv
module test_rsu_top;
  logic clk = 0;
  logic rst_n = 0;
  logic amt_wr_en = 0;
  logic [15:0] amt_wr_data = 0;
  logic [15:0] amt_rd_data;
  logic op_valid = 0;
  logic op_ready;
  logic [1:0] op_func = 0;
  logic [15:0] op_src = 0;
  logic res_valid;
  logic res_ready = 0;
  logic [15:0] res_data;

  int total = 0, bad = 0;
  bit done = 0;

  // model state
  bit        m_valid = 0;
  bit [15:0] m_data = 0;
  bit [3:0]  m_amt = 0;
  string     m_tag = "R10";

  always #5 clk = ~clk;

  rsu_top i_rsu_top (
    .clk(clk), .rst_n(rst_n), .amt_wr_en(amt_wr_en), .amt_wr_data(amt_wr_data),
    .amt_rd_data(amt_rd_data), .op_valid(op_valid), .op_ready(op_ready),
    .op_func(op_func), .op_src(op_src), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data)
  );

  function automatic bit [15:0] ref_op(bit [1:0] f, bit [15:0] s, int n);
    bit [15:0] r = s;
    for (int i = 0; i < n; i++) begin
      case (f)
        2'b00: r = {r[14:0], r[15]};
        2'b01: r = {r[0], r[15:1]};
        2'b10: r = {r[14:0], 1'b0};
        default: r = {1'b0, r[15:1]};
      endcase
    end
    return r;
  endfunction

  function automatic string tag_of(bit [1:0] f, int n);
    if (n == 0) return "R5";
    case (f)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive after negedge, check ready, model the edge, compare at negedge
  task automatic cyc(bit wv, bit [15:0] wd, bit ov, bit [1:0] f, bit [15:0] s,
                     bit rr, string wtag = "R6");
    bit acc;
    amt_wr_en = wv; amt_wr_data = wd; op_valid = ov; op_func = f; op_src = s;
    res_ready = rr;
    #1;
    chk("R9 ready", {15'b0, op_ready}, {15'b0, (!m_valid || rr)});
    acc = ov && (!m_valid || rr);
    @(posedge clk);
    if (acc) begin
      m_data = ref_op(f, s, m_amt);
      m_tag = tag_of(f, m_amt);
      m_valid = 1;
    end else if (rr) m_valid = 0;
    if (wv) m_amt = wd[3:0];
    @(negedge clk);
    chk("R9 valid", {15'b0, res_valid}, {15'b0, m_valid});
    if (m_valid) chk(m_tag, res_data, m_data);
    chk(wtag, amt_rd_data, {12'b0, m_amt});
  endtask

  initial begin
    bit [15:0] pats[5] = '{16'h8001, 16'hA5C3, 16'hFFFF, 16'h0001, 16'h7FFE};
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", {15'b0, res_valid}, 16'h0);
    chk("R10", amt_rd_data, 16'h0);
    rst_n = 1;
    @(negedge clk);
    // R1..R5 exhaustive over amounts; R6 upper bits of write discarded
    for (int a = 0; a < 16; a++) begin
      cyc(1, {12'hBEE ^ 12'(a), 4'(a)}, 0, 0, 0, 1, "R6");
      for (int f = 0; f < 4; f++)
        for (int p = 0; p < 5; p++)
          cyc(0, 0, 1, 2'(f), pats[p], 1);
    end
    // R7: write in the same cycle as an operation
    cyc(1, 16'h0003, 0, 0, 0, 1);
    cyc(1, 16'hFFF9, 1, 2'b00, 16'h1234, 1, "R7");
    cyc(0, 0, 1, 2'b00, 16'h1234, 1, "R7");
    // R8/R9: random back-pressure and traffic
    for (int i = 0; i < 400; i++)
      cyc($urandom_range(0, 5) == 0, 16'($urandom), $urandom_range(0, 2) != 0,
          2'($urandom), 16'($urandom), $urandom_range(0, 2) == 0, "R8");
    // drain
    cyc(0, 0, 0, 0, 0, 1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule